// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block turns a logical address into a physical one using a page table that is held in registers. The upper bits of the logical address pick one table entry, called the page. The lower bits pass through unchanged as the offset inside that page. The entry holds a frame number, a valid flag and a two-bit protection code. On a successful access the physical address is the frame number joined to the offset. Two things make the request trap instead of being translated: an entry that is not valid, or an access type that the entry's protection does not allow. In that case the block reports a fault and a cause code.

Software rebuilds the whole table through a sequential load port. A start pulse marks every entry invalid and opens a fill session. Each following write strobe stores the next entry in ascending page order, beginning at page 0. A small controller tracks the session. It has two states:
- `LD_IDLE`: no session is open.
- `LD_FILL`: a session is open.

It has four transitions:
- *open*: from `LD_IDLE` to `LD_FILL` on a start pulse.
- *restart*: from `LD_FILL` to `LD_FILL` on a start pulse.
- *advance*: from `LD_FILL` to `LD_FILL` on a write that is not the last one.
- *close*: from `LD_FILL` to `LD_IDLE` on the write to the last entry.

Each translation result is registered. It appears one cycle after the request.

Top module: `pxl_translate`

## Requirements
- R1: After reset, `rsp_valid` and `ld_busy` are low and every table entry is invalid.
- R2: With default widths, the page number is `req_addr[15:12]` and the offset is `req_addr[11:0]`. Both widths are parameters.
- R3: A request with `req_valid` high gives `rsp_valid` high on the next cycle. On success, `rsp_paddr` = {frame, offset}, `rsp_fault` = 0 and `rsp_cause` = 2'b00. A cycle without a request gives `rsp_valid` low on the next cycle.
- R4: A request to an invalid entry gives `rsp_fault` = 1, `rsp_cause` = 2'b01 and `rsp_paddr` = 0.
- R5: Access codes are 00 read, 01 write and 10 execute. Protection codes are 00 read-only, 01 read-write and 10 execute-only. The allowed accesses are:
  - read-only allows read only;
  - read-write allows read and write;
  - execute-only allows execute only.

  Any other pairing on a valid entry gives `rsp_fault` = 1, `rsp_cause` = 2'b10 and `rsp_paddr` = 0.
- R6: Access code 11 on any valid entry, and any access to a valid entry with protection code 11, gives the protection fault (cause 2'b10).
- R7: When an entry is invalid and the access would also break its protection, the cause is 2'b01 (invalid wins).
- R8: A `ld_start` pulse clears all valid flags and makes `ld_busy` high from the next cycle. Each `ld_wr` during a session writes {`ld_valid`, `ld_frame`, `ld_prot`} into the next entry, from page 0 upward. After the write to the last entry, `ld_busy` is low.
- R9: The following have no effect on the table:
  - `ld_wr` while `ld_busy` is low;
  - `ld_wr` in the same cycle as `ld_start`.

  A `ld_start` during a session clears the table again and restarts at page 0.
- R10: Requests made during a session see the entries written so far. Entries not yet written read as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | LADDR_W | Logical address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | FRAME_W+OFS_W | Physical address; zero on a fault |
| rsp_fault | output | 1 | Request trapped |
| rsp_cause | output | 2 | 00 none, 01 invalid page, 10 protection |
| ld_start | input | 1 | Open or restart a table load session |
| ld_wr | input | 1 | Write the next table entry |
| ld_valid | input | 1 | Valid flag for the entry being written |
| ld_frame | input | FRAME_W | Frame number for the entry being written |
| ld_prot | input | 2 | Protection code for the entry being written |
| ld_busy | output | 1 | Load session open |

## Verification
The translation result is due exactly one clock edge after the request is sampled. The bench drives on the falling edge and samples 2 ns after the next rising edge. It pairs each response with the head of an expected-result queue, and treats a missing or extra response as a failure. Table writes take effect at the edge that samples them. The bench therefore only issues a request that depends on a write after that write's edge has passed. `ld_busy` is checked one cycle after the start pulse and one cycle after the last write.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    typedef enum logic [1:0] {
        PROT_RO   = 2'b00,
        PROT_RW   = 2'b01,
        PROT_XO   = 2'b10,
        PROT_NONE = 2'b11
    } prot_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RSV = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_INVALID = 2'b01,
        CAUSE_PROT    = 2'b10,
        CAUSE_RSV     = 2'b11
    } cause_e;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;

endpackage

// File: rtl/pxl_loader.sv
module pxl_loader
    import pxl_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_start,
    input  logic             ld_wr,
    output logic             busy,
    output logic             clr_all,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    ld_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             last_wr;

    assign last_wr = (cnt_q == LAST_IDX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: begin
                if (ld_start) state_d = LD_FILL;           // open
            end
            LD_FILL: begin
                if (ld_start)              state_d = LD_FILL; // restart
                else if (ld_wr && last_wr) state_d = LD_IDLE; // close
                else                       state_d = LD_FILL; // advance / wait
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // entry counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (ld_start)   cnt_q <= '0;
        else if (wr_en)      cnt_q <= last_wr ? '0 : cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        wr_en   = 1'b0;
        clr_all = ld_start;
        wr_idx  = cnt_q;
        unique case (state_q)
            LD_IDLE: begin
                busy  = 1'b0;
                wr_en = 1'b0;
            end
            LD_FILL: begin
                busy  = 1'b1;
                wr_en = ld_wr && !ld_start;
            end
            default: begin
                busy  = 1'b0;
                wr_en = 1'b0;
            end
        endcase
    end

    // R9: with no start pulse, an idle controller stays idle
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE && !ld_start) |=> (state_q == LD_IDLE));

    // R8: a start always leaves the counter at the first entry
    a_r8_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        ld_start |=> (cnt_q == '0));

    // R8: the counter only moves while a session is open
    a_r8_count_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE) |-> (cnt_q == '0));

endmodule

// File: rtl/pxl_table.sv
module pxl_table #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [1:0]         wr_prot,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [FRAME_W-1:0] rd_frame,
    output logic [1:0]         rd_prot,
    output logic [ENTRIES-1:0] valid_all
);

    logic [ENTRIES-1:0] valid_q;
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    logic [1:0]         prot_q  [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                frame_q[e] <= '0;
                prot_q[e]  <= '0;
            end
        end else if (clr_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_idx == IDX_W'(e)) begin
                    valid_q[e] <= wr_valid;
                    frame_q[e] <= wr_frame;
                    prot_q[e]  <= wr_prot;
                end
            end
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_frame  = frame_q[rd_idx];
    assign rd_prot   = prot_q[rd_idx];
    assign valid_all = valid_q;

    // R9: without a write or clear the valid flags do not move
    a_r9_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_all) |=> $stable(valid_q));

    // R8: a write changes at most the one addressed flag
    a_r8_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> ($countones(valid_q ^ $past(valid_q)) <= 1));

endmodule

// File: rtl/pxl_check.sv
module pxl_check
    import pxl_pkg::*;
(
    input  logic       ent_valid,
    input  logic [1:0] ent_prot,
    input  logic [1:0] acc,
    output logic [1:0] cause
);

    logic allowed;

    always_comb begin
        allowed = 1'b0;
        unique case (prot_e'(ent_prot))
            PROT_RO:   allowed = (acc_e'(acc) == ACC_RD);
            PROT_RW:   allowed = (acc_e'(acc) == ACC_RD) || (acc_e'(acc) == ACC_WR);
            PROT_XO:   allowed = (acc_e'(acc) == ACC_EX);
            PROT_NONE: allowed = 1'b0;
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!ent_valid)    cause = CAUSE_INVALID;   // takes priority
        else if (!allowed) cause = CAUSE_PROT;
        else               cause = CAUSE_NONE;
    end

endmodule

// File: rtl/pxl_translate.sv
module pxl_translate
    import pxl_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int OFS_W   = 12,
    parameter int FRAME_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [LADDR_W-1:0]       req_addr,
    input  logic [1:0]               req_acc,
    output logic                     rsp_valid,
    output logic [FRAME_W+OFS_W-1:0] rsp_paddr,
    output logic                     rsp_fault,
    output logic [1:0]               rsp_cause,
    input  logic                     ld_start,
    input  logic                     ld_wr,
    input  logic                     ld_valid,
    input  logic [FRAME_W-1:0]       ld_frame,
    input  logic [1:0]               ld_prot,
    output logic                     ld_busy
);

    localparam int PAGE_W  = LADDR_W - OFS_W;
    localparam int ENTRIES = 1 << PAGE_W;
    localparam int PADDR_W = FRAME_W + OFS_W;

    logic [PAGE_W-1:0]  page;
    logic [OFS_W-1:0]   offset;
    logic               clr_all, wr_en;
    logic [PAGE_W-1:0]  wr_idx;
    logic               ent_valid;
    logic [FRAME_W-1:0] ent_frame;
    logic [1:0]         ent_prot;
    logic [ENTRIES-1:0] valid_all;
    logic [1:0]         cause;

    assign page   = req_addr[LADDR_W-1:OFS_W];
    assign offset = req_addr[OFS_W-1:0];

    pxl_loader #(.ENTRIES(ENTRIES), .IDX_W(PAGE_W)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_start(ld_start),
        .ld_wr   (ld_wr),
        .busy    (ld_busy),
        .clr_all (clr_all),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx)
    );

    pxl_table #(.ENTRIES(ENTRIES), .IDX_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (ld_valid),
        .wr_frame (ld_frame),
        .wr_prot  (ld_prot),
        .rd_idx   (page),
        .rd_valid (ent_valid),
        .rd_frame (ent_frame),
        .rd_prot  (ent_prot),
        .valid_all(valid_all)
    );

    pxl_check u_check (
        .ent_valid(ent_valid),
        .ent_prot (ent_prot),
        .acc      (req_acc),
        .cause    (cause)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_cause <= cause;
                rsp_fault <= (cause != CAUSE_NONE);
                rsp_paddr <= (cause == CAUSE_NONE) ? {ent_frame, offset} : PADDR_W'(0);
            end else begin
                rsp_cause <= CAUSE_NONE;
                rsp_fault <= 1'b0;
                rsp_paddr <= '0;
            end
        end
    end

    // R3: one response per request, one cycle later
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: a trapped access never carries an address
    a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    // R4/R5: fault flag agrees with the cause code
    a_r5_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != CAUSE_NONE)));

    // R7: a request to an entry that is not valid reports the invalid cause
    a_r7_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !valid_all[page]) |=> (rsp_cause == CAUSE_INVALID));

    // R8: start clears the table and opens the session
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ld_start |=> (valid_all == '0 && ld_busy));

endmodule

// File: tb/pxl_translate_tb_top.sv
module pxl_translate_tb_top;

    localparam int ENTRIES = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        ld_start = 1'b0;
    logic        ld_wr = 1'b0;
    logic        ld_valid = 1'b0;
    logic [3:0]  ld_frame = '0;
    logic [1:0]  ld_prot = '0;
    logic        ld_busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    pxl_translate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .ld_start(ld_start), .ld_wr(ld_wr), .ld_valid(ld_valid), .ld_frame(ld_frame),
        .ld_prot(ld_prot), .ld_busy(ld_busy)
    );

    // bench model of the table, built from what the bench has loaded
    logic       m_valid [ENTRIES];
    logic [3:0] m_frame [ENTRIES];
    logic [1:0] m_prot  [ENTRIES];
    int         m_cnt = 0;
    logic       m_busy = 1'b0;

    typedef struct {
        logic [15:0] paddr;
        logic        fault;
        logic [1:0]  cause;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic ok_access(input logic [1:0] prot, input logic [1:0] acc);
        // R5/R6 rules
        if (acc == 2'b11) return 1'b0;
        case (prot)
            2'b00:   return acc == 2'b00;
            2'b01:   return acc == 2'b00 || acc == 2'b01;
            2'b10:   return acc == 2'b10;
            default: return 1'b0;
        endcase
    endfunction

    // driver: request in this cycle, expected result pushed on the scoreboard
    task automatic do_req(input logic [15:0] addr, input logic [1:0] acc, input string tag);
        exp_t e;
        int   pg;
        pg  = int'(addr[15:12]);
        e.tag = tag;
        if (!m_valid[pg]) begin
            e.cause = 2'b01; e.fault = 1'b1; e.paddr = 16'h0;
        end else if (!ok_access(m_prot[pg], acc)) begin
            e.cause = 2'b10; e.fault = 1'b1; e.paddr = 16'h0;
        end else begin
            e.cause = 2'b00; e.fault = 1'b0; e.paddr = {m_frame[pg], addr[11:0]};
        end
        sb_q.push_back(e);
        req_valid = 1'b1; req_addr = addr; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ld_begin(input logic with_wr);
        ld_start = 1'b1;
        ld_wr    = with_wr;      // R9: a write alongside start must be dropped
        ld_valid = 1'b1; ld_frame = 4'hF; ld_prot = 2'b01;
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
        m_cnt = 0; m_busy = 1'b1;
        @(negedge clk);
        ld_start = 1'b0; ld_wr = 1'b0;
    endtask

    task automatic ld_word(input logic v, input logic [3:0] f, input logic [1:0] p);
        ld_wr = 1'b1; ld_valid = v; ld_frame = f; ld_prot = p;
        if (m_busy) begin
            m_valid[m_cnt] = v; m_frame[m_cnt] = f; m_prot[m_cnt] = p;
            m_cnt++;
            if (m_cnt == ENTRIES) begin m_cnt = 0; m_busy = 1'b0; end
        end
        @(negedge clk);
        ld_wr = 1'b0;
    endtask

    // monitor: compare each response with the head of the scoreboard
    always @(posedge clk) begin
        logic sampled;
        sampled = req_valid && rst_n;
        #2;
        if (rst_n) begin
            if (sampled && !rsp_valid) begin
                n_tests++; n_fail++;
                $display("FAIL R3: actual rsp_valid 0 expected 1");
            end else if (!sampled && rsp_valid) begin
                n_tests++; n_fail++;
                $display("FAIL R3: actual rsp_valid 1 expected 0");
            end
            if (rsp_valid && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " paddr"}, 32'(rsp_paddr), 32'(e.paddr));
                check({e.tag, " fault"}, 32'(rsp_fault), 32'(e.fault));
                check({e.tag, " cause"}, 32'(rsp_cause), 32'(e.cause));
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 1'b0; m_frame[i] = '0; m_prot[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 ld_busy", 32'(ld_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(16'h0003, 2'b00, "R1 empty table");
        do_req(16'h9ABC, 2'b10, "R4 empty table");

        // R8: full load; entry i frame (i+5)%16, prot i%4, pages 7 and 8 invalid
        ld_begin(1'b0);
        check("R8 busy after start", 32'(ld_busy), 1);
        for (int i = 0; i < ENTRIES; i++) begin
            if (i == ENTRIES - 1) check("R8 busy before last", 32'(ld_busy), 1);
            ld_word(!(i == 7 || i == 8), 4'((i + 5) % 16), 2'(i % 4));
        end
        check("R8 busy after last", 32'(ld_busy), 0);

        // R2/R3: split and join
        do_req(16'h0003, 2'b00, "R3 page0 off3");
        do_req(16'h1FFF, 2'b01, "R2 page1 top offset");
        do_req(16'hE800, 2'b10, "R2 page14 execute");
        do_req(16'hD000, 2'b00, "R3 page13 read");

        // R5/R6: protection matrix on pages 0..3 (prot codes 00..11)
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 4; a++)
                do_req({4'(p), 12'h0AB}, 2'(a), (p == 3 || a == 3) ? "R6 matrix" : "R5 matrix");

        // R4/R7: invalid entries, including a write to an invalid read-only entry
        do_req(16'h7123, 2'b00, "R4 invalid page7");
        do_req(16'h8456, 2'b01, "R7 invalid over prot");
        @(negedge clk);

        // R9: write while idle is ignored
        ld_word(1'b1, 4'hF, 2'b01);
        check("R9 busy stays low", 32'(ld_busy), 0);
        do_req(16'h8000, 2'b00, "R9 idle write page8");
        do_req(16'h0004, 2'b00, "R9 idle write page0");

        // R10: partial session
        ld_begin(1'b0);
        do_req(16'h0010, 2'b00, "R8 cleared page0");
        ld_word(1'b1, 4'h9, 2'b10);
        ld_word(1'b1, 4'h3, 2'b00);
        do_req(16'h0020, 2'b10, "R10 page0 written");
        do_req(16'h1030, 2'b00, "R10 page1 written");
        do_req(16'h2040, 2'b00, "R10 page2 pending");

        // R9: restart mid-session
        ld_begin(1'b0);
        do_req(16'h1050, 2'b00, "R9 restart clears");
        ld_word(1'b1, 4'hC, 2'b01);
        do_req(16'h0060, 2'b01, "R9 restart page0");

        // R9: start with a write in the same cycle
        ld_begin(1'b1);
        check("R9 busy after start+wr", 32'(ld_busy), 1);
        do_req(16'h0070, 2'b00, "R9 start+wr dropped");
        for (int i = 0; i < ENTRIES; i++) ld_word(1'b1, 4'(15 - i), 2'b01);
        check("R8 busy closed", 32'(ld_busy), 0);
        do_req(16'h0080, 2'b01, "R8 reload page0");
        do_req(16'hF081, 2'b00, "R8 reload page15");

        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", 32'(sb_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule